// File: doc/BRIEF.md
# DMA Channel Bus-Ownership State Controller

This block is the state machine for a single-channel DMA engine. It decides whether the channel is turned off, turned on but stopped, turned on but waiting with the bus released, or holding the bus and moving data. It drives the active-low bus request toward the CPU. It starts the transfer datapath once the bus has been granted. It also reports whether the CPU may write control bytes or read status at this moment.

Its inputs are CPU command writes (a valid strobe and a 3-bit command code), the peripheral ready line, the bus-acknowledge chain input, a strobe that fires when the CPU fetches an interrupt-return instruction, and three events from the datapath: end of block, byte match and single-byte done. The transfer mode picks one of three suspend and resume policies: byte, burst or continuous. An auto-restart flag decides whether an end of block stops the channel.

Top module: `dma_busctl`

## Requirements
- R1: `state_o` encodes 0 = disabled, 1 = enabled and stopped, 2 = enabled and suspended, 3 = active. After reset the state is disabled.
- R2: `busreq_no` is low exactly while the state is active. In every other state it is high, and it goes high in the same cycle that the state leaves active.
- R3: `cpu_access_o` is high only in the disabled and stopped states. In the active state every command is ignored. In the suspended state only DISABLE (code 2) is accepted, and it moves the channel to disabled.
- R4: An accepted ENABLE (code 1) moves the channel to active when `rdy_i` is high or the force flag is set. Otherwise it moves the channel to stopped.
- R5: Any other accepted command moves the channel to disabled. The exception is REINIT_STATUS (code 4) when no command has been accepted since reset or since the last ENABLE: in that case the state does not change.
- R6: While active, a byte match moves the channel to stopped. An end of block moves it to stopped unless `auto_restart_i` is high, in which case the channel stays active. A match takes priority over an end of block.
- R7: While active with a grant already seen, `bai_i` low moves the channel to suspended. In burst mode (1) or continuous mode (2), `rdy_i` low with the force flag clear also moves it to suspended. In byte mode (0), `rdy_i` low has no effect.
- R8: From suspended, `rdy_i` high returns the channel to active in byte or burst mode. In continuous mode it returns only on `reti_i` with `rdy_i` high.
- R9: In byte mode, `byte_done_i` while active moves the channel to suspended.
- R10: `xfer_go_o` is high in the active state from the cycle after `bai_i` is first sampled high there, and it stays high until the channel leaves active.
- R11: FORCE_READY (code 3) sets the force flag. The flag stays set until the channel stops through a match or an end of block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | CPU command write strobe |
| cmd_code_i | input | 3 | Command code (1 enable, 2 disable, 3 force ready, 4 reinit status, others plain control) |
| mode_i | input | 2 | Transfer mode: 0 byte, 1 burst, 2 continuous, 3 treated as burst |
| auto_restart_i | input | 1 | End of block does not stop the channel |
| rdy_i | input | 1 | Peripheral ready, active high |
| bai_i | input | 1 | Bus-acknowledge chain input, active high |
| reti_i | input | 1 | Interrupt-return fetch strobe |
| eob_i | input | 1 | End of block from the datapath |
| match_i | input | 1 | Byte match from the datapath |
| byte_done_i | input | 1 | Single byte transferred |
| busreq_no | output | 1 | Bus request, active low |
| xfer_go_o | output | 1 | Datapath run enable |
| cpu_access_o | output | 1 | CPU control writes and status reads allowed |
| state_o | output | 2 | Current state |

## Verification
The hardest cases to reach are the ones where several conditions must line up in time. One is a continuous-mode channel that sits suspended and then sees an interrupt-return fetch while ready is high. Another is a grant that was seen and later withdrawn in the same active period as a ready drop. A third is a REINIT_STATUS arriving as the very first command after an ENABLE. Directed sequences build each of these on purpose. Long runs of weighted random stimulus then mix rare commands and datapath events with a mostly-high ready line, so that the channel cycles through all four states many times. A bench model checks every cycle.

// File: rtl/dma_busctl_pkg.sv
package dma_busctl_pkg;
  parameter int unsigned CMD_W  = 3;
  parameter int unsigned MODE_W = 2;
  parameter int unsigned ST_W   = 2;

  typedef enum logic [ST_W-1:0] {
    ST_DIS  = 2'd0,
    ST_IDLE = 2'd1,
    ST_SUSP = 2'd2,
    ST_ACT  = 2'd3
  } dma_st_e;

  localparam logic [CMD_W-1:0] CMD_ENABLE  = 3'd1;
  localparam logic [CMD_W-1:0] CMD_DISABLE = 3'd2;
  localparam logic [CMD_W-1:0] CMD_FORCE   = 3'd3;
  localparam logic [CMD_W-1:0] CMD_REINIT  = 3'd4;

  localparam logic [MODE_W-1:0] MODE_BYTE = 2'd0;
  localparam logic [MODE_W-1:0] MODE_CONT = 2'd2;
endpackage

// File: rtl/dma_cmd_dec.sv
module dma_cmd_dec
  import dma_busctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  dma_st_e          st_i,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_code_i,
  input  logic             stop_evt_i,
  output logic             go_en_o,
  output logic             go_dis_o,
  output logic             force_o
);
  logic acc, is_en, seq_q, force_q;

  // suspended channel only listens to DISABLE; active listens to nothing
  assign acc = cmd_valid_i &
               ((st_i == ST_DIS) | (st_i == ST_IDLE) |
                ((st_i == ST_SUSP) & (cmd_code_i == CMD_DISABLE)));
  assign is_en = (cmd_code_i == CMD_ENABLE);

  assign go_en_o  = acc & is_en;
  assign go_dis_o = acc & ~is_en & ~((cmd_code_i == CMD_REINIT) & ~seq_q);
  assign force_o  = force_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q   <= 1'b0;
      force_q <= 1'b0;
    end else begin
      if (acc) seq_q <= ~is_en;
      if (acc & (cmd_code_i == CMD_FORCE)) force_q <= 1'b1;
      else if (stop_evt_i)                 force_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_mode_policy.sv
module dma_mode_policy
  import dma_busctl_pkg::*;
(
  input  dma_st_e           st_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              auto_restart_i,
  input  logic              rdy_eff_i,
  input  logic              bai_i,
  input  logic              granted_i,
  input  logic              reti_i,
  input  logic              eob_i,
  input  logic              match_i,
  input  logic              byte_done_i,
  output logic              stop_o,
  output logic              susp_o,
  output logic              resume_o
);
  logic is_byte, is_cont, active;

  assign is_byte = (mode_i == MODE_BYTE);
  assign is_cont = (mode_i == MODE_CONT);
  assign active  = (st_i == ST_ACT);

  // priority: match > end of block > grant loss > ready loss > byte done
  assign stop_o = active & (match_i | (eob_i & ~auto_restart_i));
  assign susp_o = active & ~stop_o &
                  ((granted_i & ~bai_i) |
                   (~is_byte & ~rdy_eff_i) |
                   (is_byte & byte_done_i));

  assign resume_o = (st_i == ST_SUSP) & rdy_eff_i & (~is_cont | reti_i);
endmodule

// File: rtl/dma_state_fsm.sv
module dma_state_fsm
  import dma_busctl_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    go_en_i,
  input  logic    go_dis_i,
  input  logic    rdy_eff_i,
  input  logic    stop_i,
  input  logic    susp_i,
  input  logic    resume_i,
  input  logic    bai_i,
  output dma_st_e st_o,
  output logic    granted_o
);
  dma_st_e st_q, st_d;
  logic    gr_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_DIS, ST_IDLE: begin
        if (go_en_i)       st_d = rdy_eff_i ? ST_ACT : ST_IDLE;
        else if (go_dis_i) st_d = ST_DIS;
      end
      ST_SUSP: begin
        if (go_dis_i)      st_d = ST_DIS;
        else if (resume_i) st_d = ST_ACT;
      end
      ST_ACT: begin
        if (stop_i)        st_d = ST_IDLE;
        else if (susp_i)   st_d = ST_SUSP;
      end
      default:             st_d = ST_DIS;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_DIS;
      gr_q <= 1'b0;
    end else begin
      st_q <= st_d;
      gr_q <= (st_q == ST_ACT) & (st_d == ST_ACT) & (gr_q | bai_i);
    end
  end

  assign st_o      = st_q;
  assign granted_o = gr_q;
endmodule

// File: rtl/dma_busctl.sv
module dma_busctl
  import dma_busctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_code_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              auto_restart_i,
  input  logic              rdy_i,
  input  logic              bai_i,
  input  logic              reti_i,
  input  logic              eob_i,
  input  logic              match_i,
  input  logic              byte_done_i,
  output logic              busreq_no,
  output logic              xfer_go_o,
  output logic              cpu_access_o,
  output logic [ST_W-1:0]   state_o
);
  dma_st_e st;
  logic go_en, go_dis, force_q, rdy_eff;
  logic stop, susp, resume, granted;

  assign rdy_eff = rdy_i | force_q;

  dma_cmd_dec u_dec (
    .clk_i, .rst_ni,
    .st_i(st), .cmd_valid_i, .cmd_code_i, .stop_evt_i(stop),
    .go_en_o(go_en), .go_dis_o(go_dis), .force_o(force_q)
  );

  dma_mode_policy u_pol (
    .st_i(st), .mode_i, .auto_restart_i, .rdy_eff_i(rdy_eff), .bai_i,
    .granted_i(granted), .reti_i, .eob_i, .match_i, .byte_done_i,
    .stop_o(stop), .susp_o(susp), .resume_o(resume)
  );

  dma_state_fsm u_fsm (
    .clk_i, .rst_ni,
    .go_en_i(go_en), .go_dis_i(go_dis), .rdy_eff_i(rdy_eff),
    .stop_i(stop), .susp_i(susp), .resume_i(resume), .bai_i,
    .st_o(st), .granted_o(granted)
  );

  assign busreq_no    = (st != ST_ACT);
  assign xfer_go_o    = (st == ST_ACT) & granted;
  assign cpu_access_o = (st == ST_DIS) | (st == ST_IDLE);
  assign state_o      = st;
endmodule

// File: rtl/dma_busctl_chk.sv
module dma_busctl_chk
  import dma_busctl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [CMD_W-1:0]  cmd_code_i,
  input logic [MODE_W-1:0] mode_i,
  input logic              rdy_i,
  input logic              reti_i,
  input logic              match_i,
  input logic              busreq_no,
  input logic              xfer_go_o,
  input logic              cpu_access_o,
  input logic [ST_W-1:0]   state_o
);
  // R2
  disabled_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0) |-> busreq_no);
  // R3
  active_no_cpu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3) |-> !cpu_access_o);
  // R10
  go_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_go_o |-> !busreq_no);
  // R6
  match_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3) && match_i |=> (state_o == 2'd1));
  // R8
  cont_wait_reti_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2) && (mode_i == 2'd2) && !reti_i &&
    !(cmd_valid_i && cmd_code_i == 3'd2) |=> (state_o == 2'd2));
  // R4
  enable_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0) && cmd_valid_i && (cmd_code_i == 3'd1) && rdy_i
    |=> (state_o == 2'd3) && !busreq_no);
endmodule

bind dma_busctl dma_busctl_chk u_chk (
  .clk_i, .rst_ni, .cmd_valid_i, .cmd_code_i, .mode_i, .rdy_i, .reti_i,
  .match_i, .busreq_no, .xfer_go_o, .cpu_access_o, .state_o
);

// File: tb/tb_dma_busctl.sv
module tb_dma_busctl;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cmd_valid_i = 0, auto_restart_i = 0, rdy_i = 0, bai_i = 0, reti_i = 0;
  logic eob_i = 0, match_i = 0, byte_done_i = 0;
  logic [2:0] cmd_code_i = '0;
  logic [1:0] mode_i = '0;
  logic busreq_no, xfer_go_o, cpu_access_o;
  logic [1:0] state_o;

  int n_chk = 0, n_bad = 0;
  int m_st = 0;
  bit m_seq = 0, m_force = 0, m_gr = 0;

  always #2 clk_i = ~clk_i;

  dma_busctl dut (.*);

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_next(output bit nseq, output bit nforce, output bit ngr);
    bit acc, rdy_e;
    int nst;
    acc = cmd_valid_i && (m_st == 0 || m_st == 1 || (m_st == 2 && cmd_code_i == 3'd2));
    rdy_e = rdy_i || m_force;
    nst = m_st; nseq = m_seq; nforce = m_force;
    if (acc) begin
      nseq = (cmd_code_i != 3'd1);
      if (cmd_code_i == 3'd3) nforce = 1;
    end
    case (m_st)
      0, 1: if (acc) begin
        if (cmd_code_i == 3'd1) nst = rdy_e ? 3 : 1;
        else if (!(cmd_code_i == 3'd4 && !m_seq)) nst = 0;
      end
      2: if (acc) nst = 0;
         else if (rdy_e && (mode_i != 2 || reti_i)) nst = 3;
      default: begin
        if (match_i || (eob_i && !auto_restart_i)) begin nst = 1; nforce = 0; end
        else if (m_gr && !bai_i) nst = 2;
        else if (mode_i != 0 && !rdy_e) nst = 2;
        else if (mode_i == 0 && byte_done_i) nst = 2;
      end
    endcase
    ngr = (m_st == 3 && nst == 3) && (m_gr || bai_i);
    return nst;
  endfunction

  task automatic cyc(string tag);
    bit s, f, g;
    int n;
    n = model_next(s, f, g);
    @(posedge clk_i);
    m_st = n; m_seq = s; m_force = f; m_gr = g;
    @(negedge clk_i);
    chk({tag, " R1 state"}, state_o, m_st);
    chk("R2 busreq", busreq_no, m_st != 3);
    chk("R3 access", cpu_access_o, m_st == 0 || m_st == 1);
    chk("R10 go", xfer_go_o, m_st == 3 && m_gr);
    cmd_valid_i = 0; reti_i = 0; eob_i = 0; match_i = 0; byte_done_i = 0;
  endtask

  task automatic cmd(logic [2:0] c, string tag);
    cmd_valid_i = 1; cmd_code_i = c; cyc(tag);
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #7 rst_ni = 1;
    @(negedge clk_i);
    chk("R1 reset", state_o, 0);
    chk("R2 reset", busreq_no, 1);
    // R4: enable with ready low then high
    mode_i = 1; cmd(3'd1, "R4 en-notrdy");
    chk("R4 idle", state_o, 1);
    rdy_i = 1; cmd(3'd1, "R4 en-rdy");
    chk("R4 act", state_o, 3);
    // R10: grant later
    cyc("R10 wait"); chk("R10 nogo", xfer_go_o, 0);
    bai_i = 1; cyc("R10 grant"); chk("R10 go", xfer_go_o, 1);
    // R3: command ignored while active
    cmd(3'd2, "R3 ign"); chk("R3 still act", state_o, 3);
    // R7: ready loss in burst
    rdy_i = 0; cyc("R7 rdyloss"); chk("R7 susp", state_o, 2);
    cmd(3'd5, "R3 susp-ign"); chk("R3 susp stays", state_o, 2);
    rdy_i = 1; cyc("R8 resume"); chk("R8 act", state_o, 3);
    // R7: grant loss
    cyc("R7 pre"); bai_i = 0; cyc("R7 bailoss"); chk("R7 bai susp", state_o, 2);
    // R8: continuous needs reti
    mode_i = 2; bai_i = 1; cyc("R8 cont hold"); chk("R8 cont stay", state_o, 2);
    reti_i = 1; cyc("R8 reti"); chk("R8 reti act", state_o, 3);
    // R6: auto restart and match
    auto_restart_i = 1; eob_i = 1; cyc("R6 autorst"); chk("R6 stay", state_o, 3);
    auto_restart_i = 0; eob_i = 1; match_i = 1; cyc("R6 stop"); chk("R6 idle", state_o, 1);
    // R5: reinit first after enable keeps state; after another cmd disables
    cmd(3'd1, "R5 en"); match_i = 1; cyc("R5 stop");
    cmd(3'd4, "R5 reinit-first"); chk("R5 kept", state_o, 1);
    cmd(3'd4, "R5 reinit-second"); chk("R5 dis", state_o, 0);
    // R11: force ready
    rdy_i = 0; cmd(3'd3, "R11 force"); cmd(3'd1, "R11 en"); chk("R11 act", state_o, 3);
    cyc("R11 hold"); chk("R11 no susp", state_o, 3);
    match_i = 1; cyc("R11 stop"); cmd(3'd1, "R11 cleared"); chk("R11 idle", state_o, 1);
    // R9: byte mode
    mode_i = 0; rdy_i = 1; cmd(3'd1, "R9 en");
    byte_done_i = 1; cyc("R9 done"); chk("R9 susp", state_o, 2);
    cyc("R9 rereq"); chk("R9 act", state_o, 3);
    // R3: disable accepted in suspend
    byte_done_i = 1; cyc("R3 s"); cmd(3'd2, "R3 dis"); chk("R3 dis", state_o, 0);
    // random
    for (int i = 0; i < 3000; i++) begin
      cmd_valid_i = ($urandom % 8) == 0;
      cmd_code_i = 3'($urandom);
      if (($urandom % 64) == 0) mode_i = 2'($urandom);
      auto_restart_i = ($urandom % 4) == 0;
      rdy_i = ($urandom % 8) != 0;
      bai_i = ($urandom % 6) != 0;
      reti_i = ($urandom % 5) == 0;
      eob_i = ($urandom % 20) == 0;
      match_i = ($urandom % 40) == 0;
      byte_done_i = ($urandom % 4) == 0;
      cyc("rnd");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule